// File: doc/BRIEF.md
# Payload Power Failure Latch Monitor

This block sits beside a payload power sequencer and keeps a record of the first power failure it sees. Each cycle it looks at the sequencer's 5-bit state code, the enable and power-good signal of each rail, a thermal-trip input, a manual-power indication and the management controller's payload enable. Rail-good and thermal-trip come from another domain, so each passes through a two-flop synchronizer before it is used.

A rail is watched only after it has been enabled and its synchronized good signal has been seen high once. If a watched rail then loses its good signal while still enabled, or the thermal trip fires while the sequencer is in S0, that is a failure. The block stores the state code and sets a failure flag. Both stay frozen until payload power is removed. Power is removed when the manual switch is off and the controller enable is low.

In normal operation the block also raises a one-cycle shutdown request. Manual powering counts as debug mode. In debug mode a failure in CLK_ENABLE, WAIT_100MS or S0 still gets recorded, but no shutdown request is raised.

Top module: `pfail_monitor`

## Requirements
- R1: `status_o` bit 7 is the failure flag, bits 4:0 are the captured state code, and bits 6:5 always read 0.
- R2: If `rst_n` is low at a rising edge, `status_o` becomes 8'h00, `shutdown_req_o` becomes 0 and every rail is disarmed.
- R3: A rail is armed only once its enable is high and its synchronized good signal has been high at least once. If a rail is enabled but has never been good, no failure is reported for it.
- R4: Suppose an armed, enabled rail's good input goes low before rising edge k. Then `status_o[7]` reads 1 after edge k+2, and `status_o[4:0]` holds `state_i` as it was at edge k+2. The extra edges come from the two synchronizer stages and the record register.
- R5: While `state_i` is S0 (5'h04), a synchronized thermal-trip high is a failure. In any other state the thermal trip is ignored.
- R6: Only the first failure is captured. Later failures leave `status_o` unchanged until the record is cleared.
- R7: When `manual_pwr_i` and `payload_en_i` are both low at a rising edge, `status_o` clears to 8'h00 and all rails are disarmed. While power is off, no failure is recorded.
- R8: With `manual_pwr_i` low, `shutdown_req_o` is high for exactly the one cycle in which the failure flag first reads 1.
- R9: With `manual_pwr_i` high (debug), a failure captured in CLK_ENABLE (5'h01), WAIT_100MS (parameter `ST_WAIT`, default 5'h02) or S0 (5'h04) gives no shutdown request but is still recorded. A failure in any other state still gives the pulse.
- R10: A rail whose enable goes low is disarmed at once. If its good signal drops afterwards, that is not a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset, taken from power-good |
| state_i | input | 5 | Current power sequencer state code |
| rail_en_i | input | NUM_RAILS | Per-rail enable from the sequencer |
| rail_good_i | input | NUM_RAILS | Per-rail power-good, asynchronous |
| therm_trip_i | input | 1 | Thermal trip, asynchronous, active high |
| manual_pwr_i | input | 1 | High while the board is powered manually (debug mode) |
| payload_en_i | input | 1 | Payload enable from the management controller |
| status_o | output | 8 | Failure status byte {flag, 2'b00, code} |
| shutdown_req_o | output | 1 | One-cycle shutdown request |

## Verification
The bench builds the block with four rails and the default WAIT_100MS code of 5'h02. Four rails are enough to hold one rail that never turns good, one that gets disabled before its good signal drops, and one that fails, all in the same run. Because the WAIT_100MS code is 5'h02, the bench can pick 5'h08 as a state outside the debug set. That lets it show the debug pulse both suppressed and allowed. A random phase then toggles rails, thermal trip, power sources and state codes against the behavioural model.

// File: rtl/pfail_pkg.sv
// Package: shared widths and fixed state codes for the power failure monitor.
// Assumes the sequencer uses 5-bit state codes.
package pfail_pkg;
    localparam int          STATE_W     = 5;
    localparam logic [4:0]  ST_CLK_EN   = 5'h01;
    localparam logic [4:0]  ST_S0       = 5'h04;

    typedef struct packed {
        logic             flag;
        logic [1:0]       rsvd;
        logic [STATE_W-1:0] code;
    } status_t;
endpackage

// File: rtl/pfail_sync.sv
// Module: pfail_sync
// Two-flop synchronizer for a vector of independent asynchronous levels.
// Assumes each bit is a slow level; no bus coherence is implied.
module pfail_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Two-stage capture of the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/pfail_rail_arm.sv
// Module: pfail_rail_arm
// Per-rail arming and drop detection. A rail arms after it is enabled and
// seen good once; a drop on an armed, enabled rail raises its drop bit.
// Assumes good_i is already synchronized.
module pfail_rail_arm #(
    parameter int NUM_RAILS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 power_on_i,
    input  logic [NUM_RAILS-1:0] en_i,
    input  logic [NUM_RAILS-1:0] good_i,
    output logic                 drop_o
);
    logic [NUM_RAILS-1:0] armed_q;
    logic [NUM_RAILS-1:0] drop_vec;

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        // Arm state per rail: cleared on reset, power-off or disable.
        always_ff @(posedge clk) begin
            if (!rst_n || !power_on_i) begin
                armed_q[g] <= 1'b0;
            end else begin
                armed_q[g] <= en_i[g] & (armed_q[g] | good_i[g]);
            end
        end

        // Drop flag: rail was armed, still enabled, and good has gone away.
        assign drop_vec[g] = armed_q[g] & en_i[g] & ~good_i[g];
    end

    assign drop_o = |drop_vec;
endmodule

// File: rtl/pfail_record.sv
// Module: pfail_record
// Sticky first-failure record and shutdown pulse generation.
// Assumes fail_i is already qualified by power state.
module pfail_record
    import pfail_pkg::*;
#(
    parameter logic [STATE_W-1:0] ST_WAIT = 5'h02
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               power_on_i,
    input  logic               debug_i,
    input  logic               fail_i,
    input  logic [STATE_W-1:0] state_i,
    output status_t            status_o,
    output logic               shutdown_o
);
    logic               flag_q;
    logic [STATE_W-1:0] code_q;
    logic               sd_q;
    logic               dbg_state;
    logic               capture;

    // State codes in which debug mode holds back the shutdown action.
    assign dbg_state = (state_i == ST_CLK_EN) || (state_i == ST_WAIT) ||
                       (state_i == ST_S0);
    // A new failure is taken only while no record is held and power is on.
    assign capture   = power_on_i && !flag_q && fail_i;

    // Record register: cleared on reset or power-off, otherwise sticky.
    always_ff @(posedge clk) begin
        if (!rst_n || !power_on_i) begin
            flag_q <= 1'b0;
            code_q <= '0;
        end else if (capture) begin
            flag_q <= 1'b1;
            code_q <= state_i;
        end
    end

    // Shutdown pulse: one cycle, aligned with the record being set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_q <= 1'b0;
        end else begin
            sd_q <= capture && !(debug_i && dbg_state);
        end
    end

    assign status_o.flag = flag_q;
    assign status_o.rsvd = 2'b00;
    assign status_o.code = code_q;
    assign shutdown_o    = sd_q;
endmodule

// File: rtl/pfail_monitor.sv
// Module: pfail_monitor
// Top of the payload power failure monitor. It synchronizes the rail-good and
// thermal-trip inputs, arms rails, detects failures and keeps a sticky record.
// Assumes state_i, rail_en_i, manual_pwr_i and payload_en_i are synchronous to clk.
module pfail_monitor
    import pfail_pkg::*;
#(
    parameter int                 NUM_RAILS = 4,
    parameter logic [STATE_W-1:0] ST_WAIT   = 5'h02
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [4:0]           state_i,
    input  logic [NUM_RAILS-1:0] rail_en_i,
    input  logic [NUM_RAILS-1:0] rail_good_i,
    input  logic                 therm_trip_i,
    input  logic                 manual_pwr_i,
    input  logic                 payload_en_i,
    output logic [7:0]           status_o,
    output logic                 shutdown_req_o
);
    localparam int SYNC_W = NUM_RAILS + 1;

    logic [SYNC_W-1:0]    sync_in;
    logic [SYNC_W-1:0]    sync_out;
    logic [NUM_RAILS-1:0] good_s;
    logic                 therm_s;
    logic                 power_on;
    logic                 rail_drop;
    logic                 fail;
    status_t              status;

    // Power is present while either source keeps the payload on.
    assign power_on = manual_pwr_i | payload_en_i;
    assign sync_in  = {therm_trip_i, rail_good_i};
    assign good_s   = sync_out[NUM_RAILS-1:0];
    assign therm_s  = sync_out[NUM_RAILS];

    pfail_sync #(.WIDTH(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sync_in),
        .q_o   (sync_out)
    );

    pfail_rail_arm #(.NUM_RAILS(NUM_RAILS)) u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .power_on_i (power_on),
        .en_i       (rail_en_i),
        .good_i     (good_s),
        .drop_o     (rail_drop)
    );

    // A failure is a rail drop, or a thermal trip while in S0.
    assign fail = rail_drop | (therm_s && (state_i == ST_S0));

    pfail_record #(.ST_WAIT(ST_WAIT)) u_rec (
        .clk        (clk),
        .rst_n      (rst_n),
        .power_on_i (power_on),
        .debug_i    (manual_pwr_i),
        .fail_i     (fail),
        .state_i    (state_i),
        .status_o   (status),
        .shutdown_o (shutdown_req_o)
    );

    assign status_o = status;
endmodule

// File: rtl/pfail_monitor_chk.sv
// Module: pfail_monitor_chk
// Assertion checker for pfail_monitor, bound to every instance of the top.
module pfail_monitor_chk #(
    parameter logic [4:0] ST_WAIT = 5'h02
) (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] state_i,
    input logic       manual_pwr_i,
    input logic       payload_en_i,
    input logic [7:0] status_o,
    input logic       shutdown_req_o
);
    a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:5] == 2'b00);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req_o |=> !shutdown_req_o);

    a_r8_pulse_on_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req_o |-> (status_o[7] && !$past(status_o[7])));

    a_r6_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_o[7]) && status_o[7]) |-> $stable(status_o[4:0]));

    a_r7_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!manual_pwr_i && !payload_en_i) |=> (status_o == 8'h00));

    a_r9_debug_hold: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req_o |-> !($past(manual_pwr_i) &&
            ($past(state_i) == 5'h01 || $past(state_i) == ST_WAIT ||
             $past(state_i) == 5'h04)));
endmodule

bind pfail_monitor pfail_monitor_chk #(.ST_WAIT(ST_WAIT)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .state_i        (state_i),
    .manual_pwr_i   (manual_pwr_i),
    .payload_en_i   (payload_en_i),
    .status_o       (status_o),
    .shutdown_req_o (shutdown_req_o)
);

// File: tb/pfail_monitor_bench.sv
`timescale 1ns/1ps
module pfail_monitor_bench;
    localparam int NR = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    state_i = 5'h00;
    logic [NR-1:0] rail_en_i = '0;
    logic [NR-1:0] rail_good_i = '0;
    logic          therm_trip_i = 1'b0;
    logic          manual_pwr_i = 1'b0;
    logic          payload_en_i = 1'b0;
    logic [7:0]    status_o;
    logic          shutdown_req_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    // Behavioural reference state
    bit m_g1[NR], m_g2[NR], m_arm[NR];
    bit m_t1, m_t2, m_flag, m_sd;
    int m_code;

    always #2.5 clk = ~clk;

    pfail_monitor #(.NUM_RAILS(NR), .ST_WAIT(5'h02)) u_pfail_monitor (
        .clk(clk), .rst_n(rst_n), .state_i(state_i), .rail_en_i(rail_en_i),
        .rail_good_i(rail_good_i), .therm_trip_i(therm_trip_i),
        .manual_pwr_i(manual_pwr_i), .payload_en_i(payload_en_i),
        .status_o(status_o), .shutdown_req_o(shutdown_req_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    // Reference model updated at each rising edge
    always @(posedge clk) begin
        bit pon, fail, dbg, nsd;
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) begin m_g1[i] = 0; m_g2[i] = 0; m_arm[i] = 0; end
            m_t1 = 0; m_t2 = 0; m_flag = 0; m_code = 0; m_sd = 0;
        end else begin
            pon  = manual_pwr_i || payload_en_i;
            fail = m_t2 && (state_i == 5'h04);
            for (int i = 0; i < NR; i++)
                if (m_arm[i] && rail_en_i[i] && !m_g2[i]) fail = 1;
            dbg  = (state_i == 5'h01) || (state_i == 5'h02) || (state_i == 5'h04);
            nsd  = pon && !m_flag && fail && !(manual_pwr_i && dbg);
            if (!pon) begin m_flag = 0; m_code = 0; end
            else if (!m_flag && fail) begin m_flag = 1; m_code = int'(state_i); end
            m_sd = nsd;
            for (int i = 0; i < NR; i++) begin
                m_arm[i] = pon && rail_en_i[i] && (m_arm[i] || m_g2[i]);
                m_g2[i]  = m_g1[i];
                m_g1[i]  = rail_good_i[i];
            end
            m_t2 = m_t1;
            m_t1 = therm_trip_i;
        end
    end

    // Compare against model away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(status_o[7] == m_flag, "R4 flag", status_o[7], m_flag);
            chk(int'(status_o[4:0]) == m_code, "R6 code", status_o[4:0], m_code);
            chk(status_o[6:5] == 2'b00, "R1 reserved", status_o[6:5], 0);
            chk(shutdown_req_o == m_sd, "R8 shutdown", shutdown_req_o, m_sd);
        end
    end

    // Watchdog
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic power_off();
        manual_pwr_i = 0; payload_en_i = 0; rail_en_i = '0; rail_good_i = '0;
        therm_trip_i = 0;
        step(4);
    endtask

    initial begin
        step(3);
        chk(status_o == 8'h00, "R2 reset status", status_o, 0);
        chk(shutdown_req_o == 1'b0, "R2 reset shutdown", shutdown_req_o, 0);
        rst_n = 1;

        // Controller powered, rail0 arms, rail1 enabled but never good (R3)
        payload_en_i = 1; state_i = 5'h01;
        rail_en_i = 4'b0011; rail_good_i = 4'b0001;
        step(6);
        chk(status_o == 8'h00, "R3 unarmed rail no failure", status_o, 0);
        // Rail0 drops: visible after the third edge (R4)
        rail_good_i = 4'b0000;
        step(2);
        chk(status_o[7] == 1'b0, "R4 flag not before third edge", status_o[7], 0);
        step(1);
        chk(status_o == 8'h81, "R4 captured CLK_ENABLE", status_o, 8'h81);
        chk(shutdown_req_o == 1'b1, "R8 pulse with flag", shutdown_req_o, 1);
        step(1);
        chk(shutdown_req_o == 1'b0, "R8 pulse one cycle", shutdown_req_o, 0);
        // Later thermal failure in S0 must not overwrite (R6)
        state_i = 5'h04; therm_trip_i = 1;
        step(5);
        chk(status_o == 8'h81, "R6 first failure kept", status_o, 8'h81);
        // Power off clears (R7)
        power_off();
        chk(status_o == 8'h00, "R7 cleared at power-off", status_o, 0);

        // Thermal trip outside S0 ignored, inside S0 captured (R5)
        payload_en_i = 1; state_i = 5'h01; therm_trip_i = 1;
        step(6);
        chk(status_o == 8'h00, "R5 trip ignored outside S0", status_o, 0);
        state_i = 5'h04;
        step(1);
        chk(status_o == 8'h84, "R5 trip in S0", status_o, 8'h84);
        power_off();

        // Debug mode: failure in S0 recorded, no shutdown (R9)
        manual_pwr_i = 1; state_i = 5'h04; rail_en_i = 4'b0001; rail_good_i = 4'b0001;
        step(5);
        rail_good_i = 4'b0000;
        step(3);
        chk(status_o == 8'h84, "R9 debug records S0", status_o, 8'h84);
        chk(shutdown_req_o == 1'b0, "R9 debug no shutdown", shutdown_req_o, 0);
        power_off();
        // Debug mode, state outside debug set: pulse issued (R9)
        manual_pwr_i = 1; state_i = 5'h08; rail_en_i = 4'b0010; rail_good_i = 4'b0010;
        step(5);
        rail_good_i = 4'b0000;
        step(3);
        chk(status_o == 8'h88, "R9 debug other state records", status_o, 8'h88);
        chk(shutdown_req_o == 1'b1, "R9 debug other state pulses", shutdown_req_o, 1);
        power_off();

        // Disabled rail drop not a failure (R10)
        payload_en_i = 1; state_i = 5'h04; rail_en_i = 4'b0100; rail_good_i = 4'b0100;
        step(5);
        rail_en_i = 4'b0000;
        step(1);
        rail_good_i = 4'b0000;
        step(5);
        chk(status_o == 8'h00, "R10 disabled rail ignored", status_o, 0);
        power_off();

        // Random phase against model
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(0, 40) == 0) begin
                manual_pwr_i = 1'($urandom); payload_en_i = 1'($urandom);
            end
            if ($urandom_range(0, 5) == 0) state_i = 5'($urandom_range(0, 9));
            if ($urandom_range(0, 6) == 0) rail_en_i = 4'($urandom);
            if ($urandom_range(0, 4) == 0) rail_good_i = 4'($urandom);
            if ($urandom_range(0, 30) == 0) therm_trip_i = 1'($urandom);
            if ($urandom_range(0, 500) == 0) begin rst_n = 0; step(1); rst_n = 1; end
            step(1);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule